// File: doc/BRIEF.md
# System-Management Memory Access Controller

This block sits in the memory-decode path of a host bridge and decides, for every memory request, which side of the system answers it. It holds two 8-bit control registers, a window-control register and an extended-control register, written through a simple configuration port. From their contents and from the size of memory below 4 GiB it derives three protected regions. The first is a fixed 128 KiB low window at 0xA0000. The second is a 128 KiB high alias at 0xFEDA0000 that maps onto the same DRAM bytes. The third is a protected segment of 1, 2 or 8 MiB at the top of below-4G memory.

Each request carries an address and a flag that marks it as issued in system-management mode. The controller answers one cycle later with a route code. The code selects DRAM, the PCI/VGA side, a sink that returns all ones and drops writes, or "pass", meaning the region is not claimed and normal decode applies. A lock bit, settable once per reset, closes the open window and freezes most of the control fields so that code running outside system-management mode cannot reopen the protected memory.

Top module: `smram_guard`

## Requirements
- R1: After reset the window-control register (cfg_sel = 0) reads 0x02 and the extended-control register (cfg_sel = 1) reads 0x38. The values are read back on smram_ctl and ext_ctl.
- R2: While unlocked, a write changes only bits 6 (open), 4 (lock) and 3 (global enable) of the window-control register. In the extended-control register it changes only bit 7 (high remap), bits [2:1] (segment size) and bit 0 (segment enable). All other bits keep their reset values.
- R3: When a write sets the lock bit, the open bit reads 0 from that write on, even if the same write sets it. The lock bit then stays set until reset.
- R4: While locked, only the global-enable bit of the window-control register can be written, and the extended-control register ignores writes.
- R5: Route codes are 0 DRAM, 1 PCI/VGA, 2 sink, 3 pass. A request outside system-management mode that hits the low window goes to DRAM when open = 1 and high remap = 0, and goes to PCI/VGA otherwise.
- R6: A request outside system-management mode that hits the high alias goes to DRAM only when open = 1 and high remap = 1, and gets pass otherwise.
- R7: A system-management request with global enable = 1 reaches DRAM through the low window when high remap = 0, and through the high alias when high remap = 1. In every other case it is routed like a request outside that mode.
- R8: The segment size is 1 MiB for size code 0, 2 MiB for code 1 and 8 MiB for code 2. It is zero for code 3 or when segment enable is 0; a size of zero claims no addresses.
- R9: The segment covers addresses from mem_top minus its size up to mem_top − 1, inclusive. Inside it, requests outside system-management mode get the sink and system-management requests get DRAM.
- R10: Addresses in none of the three regions, including the byte just past either window, get pass.
- R11: rsp_valid and rsp_route appear in the cycle after req_valid. The decision uses the register values held before any configuration write made in the same cycle as the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0 selects window control, 1 selects extended control |
| cfg_wdata | input | 8 | Configuration write data |
| mem_top | input | ADDR_W | Size of memory below 4 GiB, in bytes |
| req_valid | input | 1 | Request present |
| req_addr | input | ADDR_W | Request byte address |
| req_smm | input | 1 | Request issued in system-management mode |
| rsp_valid | output | 1 | Route decision present |
| rsp_route | output | 2 | Route code (see R5) |
| smram_ctl | output | 8 | Current window-control register |
| ext_ctl | output | 8 | Current extended-control register |

## Verification
A configuration write and a routed request can share a clock edge. The bench drives a write that sets the open bit in the same cycle as a low-window request outside system-management mode. It expects the PCI/VGA route for that request and the DRAM route for the next one. A write that both sets lock and tries to set open is also sent in one cycle, and the bench judges it by the register value read back and by the following low-window route.

// File: rtl/smg_pkg.sv
package smg_pkg;
   typedef enum logic [1:0] {
      RT_DRAM = 2'd0,
      RT_BUS  = 2'd1,
      RT_SINK = 2'd2,
      RT_PASS = 2'd3
   } route_e;

   // window-control bit positions
   localparam int B_OPEN = 6;
   localparam int B_LOCK = 4;
   localparam int B_GEN  = 3;
   // extended-control bit positions
   localparam int B_HRE  = 7;
   localparam int B_SZHI = 2;
   localparam int B_SZLO = 1;
   localparam int B_TEN  = 0;

   localparam logic [7:0] CTL_RST      = 8'h02;
   localparam logic [7:0] EXT_RST      = 8'h38;
   localparam logic [7:0] CTL_MASK     = 8'h58;
   localparam logic [7:0] EXT_MASK     = 8'h87;
   localparam logic [7:0] CTL_MASK_LCK = 8'h08;
   localparam logic [7:0] EXT_MASK_LCK = 8'h00;
endpackage

// File: rtl/smg_ctl_regs.sv
module smg_ctl_regs
   import smg_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cfg_we,
   input  logic       cfg_sel,
   input  logic [7:0] cfg_wdata,
   output logic [7:0] ctl_q,
   output logic [7:0] ext_q
);
   logic       locked;
   logic [7:0] ctl_mask, ext_mask, ctl_nxt, ext_nxt;

   assign locked   = ctl_q[B_LOCK];
   assign ctl_mask = locked ? CTL_MASK_LCK : CTL_MASK;
   assign ext_mask = locked ? EXT_MASK_LCK : EXT_MASK;

   always_comb begin
      ctl_nxt = ctl_q;
      ext_nxt = ext_q;
      if (cfg_we && !cfg_sel)
         ctl_nxt = (ctl_q & ~ctl_mask) | (cfg_wdata & ctl_mask);
      if (cfg_we && cfg_sel)
         ext_nxt = (ext_q & ~ext_mask) | (cfg_wdata & ext_mask);
      if (ctl_nxt[B_LOCK])
         ctl_nxt[B_OPEN] = 1'b0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctl_q <= CTL_RST;
         ext_q <= EXT_RST;
      end else begin
         ctl_q <= ctl_nxt;
         ext_q <= ext_nxt;
      end
   end

   // R3
   lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_q[B_LOCK] |=> ctl_q[B_LOCK]);
   // R3
   open_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_q[B_LOCK] |-> !ctl_q[B_OPEN]);
   // R4
   ext_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_q[B_LOCK] |=> $stable(ext_q));
endmodule

// File: rtl/smg_tseg_size.sv
module smg_tseg_size #(
   parameter int ADDR_W = 32
) (
   input  logic            ten,
   input  logic [1:0]      sz_code,
   output logic [ADDR_W:0] seg_bytes
);
   localparam logic [ADDR_W:0] ONE = {{ADDR_W{1'b0}}, 1'b1};

   always_comb begin
      seg_bytes = '0;
      if (ten) begin
         unique case (sz_code)
            2'd0:    seg_bytes = ONE << 20;
            2'd1:    seg_bytes = ONE << 21;
            2'd2:    seg_bytes = ONE << 23;
            default: seg_bytes = '0;
         endcase
      end
   end
endmodule

// File: rtl/smg_route.sv
module smg_route
   import smg_pkg::*;
#(
   parameter int              ADDR_W    = 32,
   parameter logic [ADDR_W:0] LEG_BASE  = 'h000A0000,
   parameter logic [ADDR_W:0] HI_BASE   = 'hFEDA0000,
   parameter logic [ADDR_W:0] WIN_BYTES = 'h00020000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              smm,
   input  logic              open,
   input  logic              gen,
   input  logic              hre,
   input  logic [ADDR_W:0]   seg_bytes,
   input  logic [ADDR_W-1:0] mem_top,
   output route_e            route
);
   logic [ADDR_W:0] a_x, top_x, seg_lo;
   logic            in_leg, in_hi, in_seg;

   assign a_x    = {1'b0, addr};
   assign top_x  = {1'b0, mem_top};
   assign seg_lo = top_x - seg_bytes;
   assign in_leg = (a_x >= LEG_BASE) && (a_x < LEG_BASE + WIN_BYTES);
   assign in_hi  = (a_x >= HI_BASE) && (a_x < HI_BASE + WIN_BYTES);
   assign in_seg = (seg_bytes != '0) && (a_x >= seg_lo) && (a_x < top_x);

   always_comb begin
      route = RT_PASS;
      if (in_leg) begin
         if (smm && gen && !hre)  route = RT_DRAM;
         else if (open && !hre)   route = RT_DRAM;
         else                     route = RT_BUS;
      end else if (in_hi) begin
         if (smm && gen && hre)   route = RT_DRAM;
         else if (open && hre)    route = RT_DRAM;
      end else if (in_seg) begin
         route = smm ? RT_DRAM : RT_SINK;
      end
   end

   // R9
   smm_no_sink_chk: assert property (@(posedge clk) disable iff (!rst_n)
      smm |-> route != RT_SINK);
endmodule

// File: rtl/smram_guard.sv
module smram_guard
   import smg_pkg::*;
#(
   parameter int              ADDR_W    = 32,
   parameter logic [ADDR_W:0] LEG_BASE  = 'h000A0000,
   parameter logic [ADDR_W:0] HI_BASE   = 'hFEDA0000,
   parameter logic [ADDR_W:0] WIN_BYTES = 'h00020000,
   parameter bit              REG_OUT   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic              cfg_sel,
   input  logic [7:0]        cfg_wdata,
   input  logic [ADDR_W-1:0] mem_top,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic              req_smm,
   output logic              rsp_valid,
   output logic [1:0]        rsp_route,
   output logic [7:0]        smram_ctl,
   output logic [7:0]        ext_ctl
);
   localparam logic [ADDR_W:0] SPACE = {1'b1, {ADDR_W{1'b0}}};

   if (ADDR_W < 24 || ADDR_W > 32) begin : g_bad_width
      $error("smram_guard: ADDR_W must lie in 24..32");
   end
   if (WIN_BYTES == '0 || HI_BASE + WIN_BYTES > SPACE) begin : g_bad_window
      $error("smram_guard: window must be non-empty and inside the space");
   end

   logic [7:0]      ctl_q, ext_q;
   logic [ADDR_W:0] seg_bytes;
   route_e          route;

   smg_ctl_regs u_regs (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
      .cfg_wdata(cfg_wdata), .ctl_q(ctl_q), .ext_q(ext_q)
   );

   smg_tseg_size #(.ADDR_W(ADDR_W)) u_size (
      .ten(ext_q[B_TEN]), .sz_code(ext_q[B_SZHI:B_SZLO]), .seg_bytes(seg_bytes)
   );

   smg_route #(
      .ADDR_W(ADDR_W), .LEG_BASE(LEG_BASE), .HI_BASE(HI_BASE), .WIN_BYTES(WIN_BYTES)
   ) u_route (
      .clk(clk), .rst_n(rst_n), .addr(req_addr), .smm(req_smm),
      .open(ctl_q[B_OPEN]), .gen(ctl_q[B_GEN]), .hre(ext_q[B_HRE]),
      .seg_bytes(seg_bytes), .mem_top(mem_top), .route(route)
   );

   if (REG_OUT) begin : g_reg_out
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_route <= RT_PASS;
         end else begin
            rsp_valid <= req_valid;
            rsp_route <= route;
         end
      end
      // R11
      rsp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
         req_valid |=> rsp_valid);
   end else begin : g_comb_out
      assign rsp_valid = req_valid;
      assign rsp_route = route;
   end

   assign smram_ctl = ctl_q;
   assign ext_ctl   = ext_q;
endmodule

// File: tb/sim_smram_guard.sv
module sim_smram_guard;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic        cfg_sel = 1'b0;
   logic [7:0]  cfg_wdata = 8'h00;
   logic [31:0] mem_top = 32'h8000_0000;
   logic        req_valid = 1'b0;
   logic [31:0] req_addr = '0;
   logic        req_smm = 1'b0;
   logic        rsp_valid;
   logic [1:0]  rsp_route;
   logic [7:0]  smram_ctl, ext_ctl;

   int checks = 0;
   int fails  = 0;
   int exp_q[$];
   string tag_q[$];

   localparam int DRAM = 0, BUS = 1, SINK = 2, PASS = 3;

   always #5 clk = ~clk;

   smram_guard u0 (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
      .cfg_wdata(cfg_wdata), .mem_top(mem_top), .req_valid(req_valid),
      .req_addr(req_addr), .req_smm(req_smm), .rsp_valid(rsp_valid),
      .rsp_route(rsp_route), .smram_ctl(smram_ctl), .ext_ctl(ext_ctl)
   );

   // monitor: pops expected routes as responses arrive
   always @(negedge clk) begin
      if (rst_n && rsp_valid) begin
         checks++;
         if (exp_q.size() == 0) begin
            fails++;
            $display("FAIL unexpected response: actual %0d expected none", rsp_route);
         end else begin
            automatic int e = exp_q.pop_front();
            automatic string t = tag_q.pop_front();
            if (int'(rsp_route) != e) begin
               fails++;
               $display("FAIL %s: route actual %0d expected %0d", t, rsp_route, e);
            end
         end
      end
   end

   task automatic access(input logic [31:0] a, input logic smm, input int e, input string t);
      @(negedge clk);
      req_valid = 1'b1; req_addr = a; req_smm = smm;
      exp_q.push_back(e); tag_q.push_back(t);
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic wr(input logic sel, input logic [7:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic chk_regs(input logic [7:0] c, input logic [7:0] x, input string t);
      checks++;
      if (smram_ctl !== c || ext_ctl !== x) begin
         fails++;
         $display("FAIL %s: regs actual %h/%h expected %h/%h", t, smram_ctl, ext_ctl, c, x);
      end
   endtask

   task automatic do_reset();
      @(negedge clk); rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      do_reset();
      @(negedge clk);
      chk_regs(8'h02, 8'h38, "R1 reset values");
      access(32'h000A_0000, 0, BUS,  "R5 closed low window");
      access(32'hFEDA_0000, 0, PASS, "R6 alias undecoded at reset");
      access(32'h7FFF_FFFF, 0, PASS, "R8 segment disabled");
      access(32'h0010_0000, 0, PASS, "R10 ordinary address");

      wr(0, 8'hAF); chk_regs(8'h0A, 8'h38, "R2 window mask");
      wr(1, 8'h00); chk_regs(8'h0A, 8'h38, "R2 ext fixed bits");
      wr(1, 8'hFF); chk_regs(8'h0A, 8'hBF, "R2 ext all writable");

      wr(0, 8'h48); wr(1, 8'h00); chk_regs(8'h4A, 8'h38, "R2 open+gen");
      access(32'h000B_FFFF, 0, DRAM, "R5 open low window");
      access(32'hFEDA_0000, 0, PASS, "R6 open no remap");
      access(32'h000A_0000, 1, DRAM, "R7 smm low");
      access(32'hFEDA_0000, 1, PASS, "R7 smm alias no remap");
      access(32'h000C_0000, 0, PASS, "R10 past low window");

      wr(1, 8'h80);
      access(32'h000A_0000, 0, BUS,  "R5 remap hides low");
      access(32'hFEDA_0000, 0, DRAM, "R6 alias open");
      access(32'hFEDB_FFFF, 0, DRAM, "R6 alias last byte");
      access(32'hFEDC_0000, 0, PASS, "R10 past alias");
      access(32'h000A_0000, 1, BUS,  "R7 smm low with remap");
      access(32'hFEDA_0000, 1, DRAM, "R7 smm alias");

      wr(0, 8'h08);
      access(32'hFEDA_0000, 0, PASS, "R6 closed alias");
      access(32'hFEDA_0000, 1, DRAM, "R7 smm alias closed");
      wr(0, 8'h00);
      access(32'hFEDA_0000, 1, PASS, "R7 gen clear alias");
      access(32'h000A_0000, 1, BUS,  "R7 gen clear low");

      wr(1, 8'h01); chk_regs(8'h02, 8'h39, "R2 segment on");
      access(32'h7FF0_0000, 0, SINK, "R9 seg low bound");
      access(32'h7FEF_FFFF, 0, PASS, "R9 below seg");
      access(32'h7FFF_FFFF, 0, SINK, "R9 seg top byte");
      access(32'h8000_0000, 0, PASS, "R9 at mem_top");
      access(32'h7FF0_0000, 1, DRAM, "R9 smm seg");
      wr(1, 8'h03);
      access(32'h7FE0_0000, 0, SINK, "R8 2MiB in");
      access(32'h7FDF_FFFF, 0, PASS, "R8 2MiB out");
      wr(1, 8'h05);
      access(32'h7F80_0000, 0, SINK, "R8 8MiB in");
      access(32'h7F7F_FFFF, 0, PASS, "R8 8MiB out");
      wr(1, 8'h07);
      access(32'h7FFF_FFFF, 0, PASS, "R8 code3 zero");
      wr(1, 8'h04);
      access(32'h7FFF_FFFF, 0, PASS, "R8 enable clear");
      wr(1, 8'h01);
      mem_top = 32'h4000_0000;
      access(32'h3FF0_0000, 0, SINK, "R9 moved top");
      access(32'h7FFF_FFFF, 0, PASS, "R9 old top gone");

      // same-cycle write and request
      @(negedge clk);
      cfg_we = 1'b1; cfg_sel = 1'b0; cfg_wdata = 8'h48;
      req_valid = 1'b1; req_addr = 32'h000A_0000; req_smm = 1'b0;
      exp_q.push_back(BUS); tag_q.push_back("R11 old state used");
      @(negedge clk);
      cfg_we = 1'b0; req_valid = 1'b0;
      access(32'h000A_0000, 0, DRAM, "R11 new state next");

      wr(0, 8'h58); chk_regs(8'h1A, 8'h39, "R3 lock clears open");
      access(32'h000A_0000, 0, BUS, "R3 locked low closed");
      wr(0, 8'h40); chk_regs(8'h12, 8'h39, "R4 only gen writable");
      wr(1, 8'h80); chk_regs(8'h12, 8'h39, "R4 ext frozen");
      access(32'hFEDA_0000, 0, PASS, "R4 alias stays off");
      wr(0, 8'h08); chk_regs(8'h1A, 8'h39, "R4 gen set locked");

      repeat (3) @(negedge clk);
      checks++;
      if (exp_q.size() != 0) begin
         fails++;
         $display("FAIL R11 missing responses: actual %0d pending expected 0", exp_q.size());
      end
      do_reset();
      @(negedge clk);
      chk_regs(8'h02, 8'h38, "R1 R3 reset clears lock");
      finish_run();
   end
endmodule